// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that watches for software hangs. It counts ticks from one of four tick sources. The ticks go first through a prescaler and then through a power-of-two postscaler. If software does not service the watchdog before the count runs out, the block issues a reset request. With windowed operation enabled, servicing the watchdog too soon is treated as a fault too. A service that arrives before the window near the end of the period opens also raises a reset request.

The configuration fields are meant to be tied to a write-once configuration word and held static. Software services the watchdog with a clear strobe. In the mode that hands control to software, it also drives an enable bit. Two sticky flags record why the last reset request happened, and a separate strobe clears them. The oscillators are modelled as single-cycle tick enables in the system clock domain. The block only chooses which tick enable to count.

Top module: `wdog_top`

## Requirements
- R1: After reset is released, `rst_req`, `st_timeout` and `st_winviol` are low, and both counters start from zero.
- R2: While enabled with no service, the counter reaches its limit on tick number P = prescale × 2^`cfg_post` of the selected source. One system clock later, `rst_req` is high for one cycle and `st_timeout` is set. The count then restarts from zero.
- R3: `cfg_pre_big` = 1 selects a prescale of PRE_LARGE (128 by default). `cfg_pre_big` = 0 selects PRE_SMALL (32 by default).
- R4: The encoding of `cfg_en_mode` is as follows. 2'b11 means always counting. 2'b10 means counting only while `sw_enable` is 1. 2'b01 means counting only while `in_sleep` is 0, whatever `sw_enable` is. 2'b00 means never counting, whatever `sw_enable` is.
- R5: While disabled, both counters are held at zero, so re-enabling the block starts a full period.
- R6: An accepted `sw_clear` returns both counters to zero without a reset request. A full period P is then needed again before the next timeout.
- R7: With `cfg_win_off` = 0, a `sw_clear` given before the window opens raises `rst_req` one cycle later and sets `st_winviol`. A `sw_clear` given while the block is disabled has no effect.
- R8: With `cfg_win_off` = 0, the window opens once the elapsed tick count reaches a point set by `cfg_win_width`. For 2'b11 that point is 3P/4, for 2'b10 it is 5P/8, for 2'b01 it is P/2, and for 2'b00 it is P/4. A clear at or after that count is accepted.
- R9: With `cfg_win_off` = 1, a clear is accepted at any count.
- R10: With `cfg_mux_on` = 0, only `tick_lprc` advances the count.
- R11: With `cfg_mux_on` = 1, `cfg_src_sel` picks the source. 2'b11 picks `tick_lprc`. 2'b01 picks `tick_sosc`. 2'b10 picks `tick_frc` only when the window is on, `sys_on_lprc` = 0 and `in_sleep` = 0, and `tick_lprc` otherwise. 2'b00 picks `tick_pclk` only when `sys_on_lprc` = 0 and `in_sleep` = 0, and `tick_lprc` otherwise.
- R12: A `flag_clr` strobe clears both status flags on the next edge. A new reset cause in the same cycle takes priority over the strobe.
- R13: When a change of `in_sleep` or `sys_on_lprc` changes the source, the new source is counted from the next tick and the count already accumulated is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_mode | input | 2 | Enable mode code (R4) |
| cfg_win_off | input | 1 | 1 = window off, 0 = windowed operation |
| cfg_win_width | input | 2 | Window width code (R8) |
| cfg_pre_big | input | 1 | Prescale select (R3) |
| cfg_mux_on | input | 1 | 1 = source chosen by `cfg_src_sel` |
| cfg_src_sel | input | 2 | Tick source code (R11) |
| cfg_post | input | PS_W | Postscale exponent |
| tick_lprc | input | 1 | Low-power RC tick enable |
| tick_frc | input | 1 | Fast RC tick enable |
| tick_sosc | input | 1 | Secondary oscillator tick enable |
| tick_pclk | input | 1 | Peripheral clock tick enable |
| in_sleep | input | 1 | Device is in sleep |
| sys_on_lprc | input | 1 | System clock runs from the low-power RC |
| sw_clear | input | 1 | Software service strobe |
| sw_enable | input | 1 | Software enable bit |
| flag_clr | input | 1 | Clears the status flags |
| rst_req | output | 1 | One-cycle reset request |
| st_timeout | output | 1 | Sticky flag: last request came from a timeout |
| st_winviol | output | 1 | Sticky flag: last request came from an early clear |

## Verification
The bench builds the block with PRE_SMALL = 4 and PRE_LARGE = 8, and uses postscale exponents of 1 and 2. Periods are then 8 to 32 ticks. At that size the bench can count every timeout to the exact tick. It can also test every window-width code on both sides of its opening point, one tick early and exactly on time. The short periods also let the bench try each source code under both sleep states and both system-clock states, and move the source partway through a period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    SRC_LPRC = 2'd0,
    SRC_FRC  = 2'd1,
    SRC_SOSC = 2'd2,
    SRC_PCLK = 2'd3
  } wdog_src_e;

  // Tick count at which the clear window opens, for a period in ticks.
  // The share is counted in eighths of the period and taken off its end.
  function automatic logic [31:0] win_open_at(input logic [31:0] period,
                                              input logic [1:0]  code);
    logic [31:0] eighths;
    case (code)
      2'b11:   eighths = 32'd2;
      2'b10:   eighths = 32'd3;
      2'b01:   eighths = 32'd4;
      default: eighths = 32'd6;
    endcase
    return period - ((period * eighths) >> 3);
  endfunction

  // Total ticks elapsed, from the postscale count and the prescale count.
  function automatic logic [31:0] ticks_done(input logic [31:0] post,
                                             input logic [31:0] pre,
                                             input logic [4:0]  pre_lg);
    return (post << pre_lg) + pre;
  endfunction

endpackage

// File: rtl/wdog_src_sel.sv
module wdog_src_sel
  import wdog_pkg::*;
(
  input  logic       cfg_mux_on,
  input  logic [1:0] cfg_src_sel,
  input  logic       cfg_win_off,
  input  logic       in_sleep,
  input  logic       sys_on_lprc,
  input  logic       tick_lprc,
  input  logic       tick_frc,
  input  logic       tick_sosc,
  input  logic       tick_pclk,
  output wdog_src_e  src,
  output logic       src_tick
);

  logic fast_ok;
  assign fast_ok = !sys_on_lprc && !in_sleep;

  always_comb begin
    src = SRC_LPRC;
    if (cfg_mux_on) begin
      case (cfg_src_sel)
        2'b11: src = SRC_LPRC;
        2'b10: src = (fast_ok && !cfg_win_off) ? SRC_FRC : SRC_LPRC;
        2'b01: src = SRC_SOSC;
        default: src = fast_ok ? SRC_PCLK : SRC_LPRC;
      endcase
    end
  end

  always_comb begin
    case (src)
      SRC_FRC:  src_tick = tick_frc;
      SRC_SOSC: src_tick = tick_sosc;
      SRC_PCLK: src_tick = tick_pclk;
      default:  src_tick = tick_lprc;
    endcase
  end

  // R10
  always_comb begin
    if (!cfg_mux_on) begin
      lprc_only_chk: assert (src_tick == tick_lprc);
    end
  end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int PRE_SMALL = 32,
  parameter int PRE_LARGE = 128,
  parameter int PS_W      = 4,
  localparam int PRE_W    = $clog2(PRE_LARGE),
  localparam int POST_CW  = (1 << PS_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               restart,
  input  logic               pre_big,
  input  logic [PS_W-1:0]    ps,
  output logic [PRE_W-1:0]   pre_q,
  output logic [POST_CW-1:0] post_q,
  output logic               expire
);

  logic [PRE_W-1:0]   pre_max;
  logic [POST_CW-1:0] post_max;
  logic               pre_wrap;

  assign pre_max  = pre_big ? PRE_W'(PRE_LARGE - 1) : PRE_W'(PRE_SMALL - 1);
  assign post_max = POST_CW'((32'd1 << ps) - 32'd1);
  assign pre_wrap = (pre_q == pre_max);
  assign expire   = run && tick && pre_wrap && (post_q == post_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (!run || restart) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (tick) begin
      if (pre_wrap) begin
        pre_q  <= '0;
        post_q <= (post_q == post_max) ? '0 : post_q + 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end

  // R5
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0 && post_q == '0));

  // R13
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !restart) |=> ($stable(pre_q) && $stable(post_q)));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PRE_SMALL = 32,
  parameter int PRE_LARGE = 128,
  parameter int PS_W      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_en_mode,
  input  logic            cfg_win_off,
  input  logic [1:0]      cfg_win_width,
  input  logic            cfg_pre_big,
  input  logic            cfg_mux_on,
  input  logic [1:0]      cfg_src_sel,
  input  logic [PS_W-1:0] cfg_post,
  input  logic            tick_lprc,
  input  logic            tick_frc,
  input  logic            tick_sosc,
  input  logic            tick_pclk,
  input  logic            in_sleep,
  input  logic            sys_on_lprc,
  input  logic            sw_clear,
  input  logic            sw_enable,
  input  logic            flag_clr,
  output logic            rst_req,
  output logic            st_timeout,
  output logic            st_winviol
);

  localparam int PRE_W   = $clog2(PRE_LARGE);
  localparam int POST_CW = (1 << PS_W) - 1;
  localparam logic [4:0] LG_SMALL = 5'($clog2(PRE_SMALL));
  localparam logic [4:0] LG_LARGE = 5'($clog2(PRE_LARGE));

  wdog_src_e          src;
  logic               src_tick;
  logic               wd_en;
  logic [PRE_W-1:0]   pre_q;
  logic [POST_CW-1:0] post_q;
  logic               expire;
  logic               clr_seen;
  logic               early_clr;
  logic               fire_to;
  logic               fire_wv;
  logic               restart;
  logic [4:0]         pre_lg;
  logic [31:0]        elapsed;
  logic [31:0]        period;
  logic [31:0]        open_at;

  always_comb begin
    case (cfg_en_mode)
      2'b11:   wd_en = 1'b1;
      2'b10:   wd_en = sw_enable;
      2'b01:   wd_en = !in_sleep;
      default: wd_en = 1'b0;
    endcase
  end

  wdog_src_sel u_src (
    .cfg_mux_on (cfg_mux_on),
    .cfg_src_sel(cfg_src_sel),
    .cfg_win_off(cfg_win_off),
    .in_sleep   (in_sleep),
    .sys_on_lprc(sys_on_lprc),
    .tick_lprc  (tick_lprc),
    .tick_frc   (tick_frc),
    .tick_sosc  (tick_sosc),
    .tick_pclk  (tick_pclk),
    .src        (src),
    .src_tick   (src_tick)
  );

  wdog_count #(
    .PRE_SMALL(PRE_SMALL),
    .PRE_LARGE(PRE_LARGE),
    .PS_W     (PS_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wd_en),
    .tick   (src_tick),
    .restart(restart),
    .pre_big(cfg_pre_big),
    .ps     (cfg_post),
    .pre_q  (pre_q),
    .post_q (post_q),
    .expire (expire)
  );

  assign pre_lg    = cfg_pre_big ? LG_LARGE : LG_SMALL;
  assign elapsed   = ticks_done(32'(post_q), 32'(pre_q), pre_lg);
  assign period    = 32'd1 << (pre_lg + 5'(cfg_post));
  assign open_at   = win_open_at(period, cfg_win_width);
  assign clr_seen  = wd_en && sw_clear;
  assign early_clr = clr_seen && !cfg_win_off && (elapsed < open_at);
  assign fire_wv   = early_clr;
  assign fire_to   = expire && !clr_seen;
  assign restart   = clr_seen || fire_to;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req    <= 1'b0;
      st_timeout <= 1'b0;
      st_winviol <= 1'b0;
    end else begin
      rst_req <= fire_to || fire_wv;
      if (fire_to)       st_timeout <= 1'b1;
      else if (flag_clr) st_timeout <= 1'b0;
      if (fire_wv)       st_winviol <= 1'b1;
      else if (flag_clr) st_winviol <= 1'b0;
    end
  end

  // R2
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_timeout) |-> rst_req);

  // R7
  winviol_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_winviol) |-> ($past(!cfg_win_off) && rst_req));

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fire_to && !fire_wv) |=> (!st_timeout && !st_winviol));

  // R9
  no_window_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_win_off |-> !early_clr);

endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;

  localparam int CLK_PERIOD = 10;
  localparam int PS_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      cfg_en_mode = 2'b11;
  logic            cfg_win_off = 1'b1;
  logic [1:0]      cfg_win_width = 2'b11;
  logic            cfg_pre_big = 1'b1;
  logic            cfg_mux_on = 1'b0;
  logic [1:0]      cfg_src_sel = 2'b11;
  logic [PS_W-1:0] cfg_post = 4'd2;
  logic            tick_lprc = 1'b0, tick_frc = 1'b0, tick_sosc = 1'b0, tick_pclk = 1'b0;
  logic            in_sleep = 1'b0, sys_on_lprc = 1'b0;
  logic            sw_clear = 1'b0, sw_enable = 1'b0, flag_clr = 1'b0;
  logic            rst_req, st_timeout, st_winviol;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_top #(.PRE_SMALL(4), .PRE_LARGE(8), .PS_W(PS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en_mode(cfg_en_mode), .cfg_win_off(cfg_win_off),
    .cfg_win_width(cfg_win_width), .cfg_pre_big(cfg_pre_big), .cfg_mux_on(cfg_mux_on),
    .cfg_src_sel(cfg_src_sel), .cfg_post(cfg_post), .tick_lprc(tick_lprc),
    .tick_frc(tick_frc), .tick_sosc(tick_sosc), .tick_pclk(tick_pclk),
    .in_sleep(in_sleep), .sys_on_lprc(sys_on_lprc), .sw_clear(sw_clear),
    .sw_enable(sw_enable), .flag_clr(flag_clr), .rst_req(rst_req),
    .st_timeout(st_timeout), .st_winviol(st_winviol)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Period in ticks, worked out from the prescale choice and exponent.
  function automatic int period_of(input bit big, input int ps);
    int pre = big ? 8 : 4;
    for (int i = 0; i < ps; i++) pre = pre * 2;
    return pre;
  endfunction

  // srcs bit 0 lprc, 1 frc, 2 sosc, 3 pclk; hits counts reset requests.
  task automatic pulse(input logic [3:0] srcs, input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {tick_pclk, tick_sosc, tick_frc, tick_lprc} = srcs;
      @(negedge clk);
      {tick_pclk, tick_sosc, tick_frc, tick_lprc} = 4'b0;
      if (rst_req) hits++;
    end
  endtask

  task automatic kick(output int hit);
    @(negedge clk); sw_clear = 1'b1;
    @(negedge clk); sw_clear = 1'b0;
    hit = int'(rst_req);
  endtask

  task automatic zero_counts();
    logic [1:0] keep;
    keep = cfg_en_mode;
    @(negedge clk); cfg_en_mode = 2'b00; flag_clr = 1'b1;
    @(negedge clk); cfg_en_mode = keep;  flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rst_req after reset", int'(rst_req), 0);
    check("R1 st_timeout after reset", int'(st_timeout), 0);
    check("R1 st_winviol after reset", int'(st_winviol), 0);
  endtask

  task automatic t_timeout();
    int h, p;
    for (int b = 0; b < 2; b++) begin
      cfg_pre_big = b[0]; cfg_post = (b == 0) ? 4'd1 : 4'd2;
      p = period_of(b[0], int'(cfg_post));
      zero_counts();
      pulse(4'b0001, p - 1, h);
      check("R3 no request before P", h, 0);
      pulse(4'b0001, 1, h);
      check("R2 request on tick P", h, 1);
      check("R2 st_timeout set", int'(st_timeout), 1);
      @(negedge clk);
      check("R2 one-cycle pulse", int'(rst_req), 0);
    end
  endtask

  task automatic t_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R12 flag_clr clears timeout", int'(st_timeout), 0);
  endtask

  task automatic t_enable();
    int h, p;
    cfg_pre_big = 1'b1; cfg_post = 4'd2; p = period_of(1'b1, 2);
    cfg_en_mode = 2'b00; sw_enable = 1'b1;
    pulse(4'b0001, p + 4, h);
    check("R4 mode 00 never counts", h, 0);
    kick(h);
    check("R7 clear while disabled ignored", h, 0);
    cfg_en_mode = 2'b10; sw_enable = 1'b0;
    pulse(4'b0001, p + 4, h);
    check("R4 mode 10 with sw_enable low", h, 0);
    sw_enable = 1'b1;
    pulse(4'b0001, p, h);
    check("R4 mode 10 with sw_enable high", h, 1);
    cfg_en_mode = 2'b01; sw_enable = 1'b0; in_sleep = 1'b1;
    pulse(4'b0001, p + 4, h);
    check("R4 mode 01 stopped in sleep", h, 0);
    in_sleep = 1'b0;
    pulse(4'b0001, p, h);
    check("R4 mode 01 counts while active", h, 1);
    cfg_en_mode = 2'b11;
  endtask

  task automatic t_hold();
    int h, p;
    p = period_of(1'b1, 2);
    zero_counts();
    pulse(4'b0001, p - 3, h);
    zero_counts();
    pulse(4'b0001, p - 1, h);
    check("R5 full period after re-enable", h, 0);
    pulse(4'b0001, 1, h);
    check("R5 request at P after re-enable", h, 1);
  endtask

  task automatic t_clear_nowin();
    int h, p;
    p = period_of(1'b1, 2);
    cfg_win_off = 1'b1;
    zero_counts();
    kick(h);
    check("R9 clear at zero count accepted", h, 0);
    pulse(4'b0001, p - 1, h);
    kick(h);
    check("R9 clear near end accepted", h, 0);
    pulse(4'b0001, p - 1, h);
    check("R6 clear restarts the period", h, 0);
    pulse(4'b0001, 1, h);
    check("R6 request a full period after clear", h, 1);
  endtask

  task automatic t_window();
    int h, p, op;
    int pct[4];
    pct[0] = 250; pct[1] = 500; pct[2] = 625; pct[3] = 750;
    p = period_of(1'b1, 2);
    cfg_win_off = 1'b0;
    for (int w = 0; w < 4; w++) begin
      cfg_win_width = 2'(w);
      op = (p * pct[w]) / 1000;
      zero_counts();
      pulse(4'b0001, op - 1, h);
      kick(h);
      check("R7 early clear raises request", h, 1);
      check("R7 st_winviol set", int'(st_winviol), 1);
      check("R7 no timeout flag on early clear", int'(st_timeout), 0);
      zero_counts();
      pulse(4'b0001, op, h);
      kick(h);
      check("R8 clear at window opening accepted", h, 0);
      check("R12 flag_clr cleared st_winviol", int'(st_winviol), 0);
    end
    cfg_win_off = 1'b1;
  endtask

  task automatic t_src();
    int h, p;
    p = period_of(1'b1, 2);
    cfg_mux_on = 1'b0;
    zero_counts();
    pulse(4'b1110, p + 4, h);
    check("R10 mux off ignores other sources", h, 0);
    cfg_mux_on = 1'b1; cfg_src_sel = 2'b01;
    zero_counts();
    pulse(4'b1011, p + 4, h);
    check("R11 sosc code ignores lprc", h, 0);
    pulse(4'b0100, p, h);
    check("R11 sosc code counts sosc", h, 1);
    cfg_src_sel = 2'b00; sys_on_lprc = 1'b1;
    zero_counts();
    pulse(4'b1000, p + 4, h);
    check("R11 pclk code with system on lprc ignores pclk", h, 0);
    sys_on_lprc = 1'b0;
    zero_counts();
    pulse(4'b1000, p, h);
    check("R11 pclk code awake counts pclk", h, 1);
    cfg_src_sel = 2'b10; cfg_win_off = 1'b1;
    zero_counts();
    pulse(4'b0010, p + 4, h);
    check("R11 frc code with window off ignores frc", h, 0);
    cfg_win_off = 1'b0; cfg_win_width = 2'b00;
    zero_counts();
    pulse(4'b0010, p, h);
    check("R11 frc code with window on counts frc", h, 1);
    cfg_win_off = 1'b1;
    cfg_src_sel = 2'b11;
    zero_counts();
    pulse(4'b1110, p + 4, h);
    check("R11 lprc code ignores others", h, 0);
  endtask

  task automatic t_switch();
    int h, p;
    p = period_of(1'b1, 2);
    cfg_mux_on = 1'b1; cfg_src_sel = 2'b00; in_sleep = 1'b0;
    zero_counts();
    pulse(4'b1000, p / 2, h);
    in_sleep = 1'b1;
    pulse(4'b1000, 5, h);
    check("R13 pclk ignored in sleep", h, 0);
    pulse(4'b0001, p / 2 - 1, h);
    check("R13 count kept across switch", h, 0);
    pulse(4'b0001, 1, h);
    check("R13 request at P across switch", h, 1);
    in_sleep = 1'b0; cfg_mux_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timeout();
    t_flags();
    t_enable();
    t_hold();
    t_clear_nowin();
    t_window();
    t_src();
    t_switch();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule